// File: doc/BRIEF.md
# Three-Sensor Flame-Seeking Controller

This block is a synchronous state machine that steers a two-wheel differential robot toward a light source. It then runs a blower until the source goes dark, and afterwards drives the robot back along the path it came. Three comparator outputs (left, middle and right light detectors) arrive unsynchronized. The block brings each one into the clock domain and accepts a new level only once it has stayed put for a set number of timebase ticks. A push-button starts the run. Every step of movement and timing advances on a one-clock `tick` pulse from an outside timebase.

Each wheel has a forward enable and a reverse enable. There is also a fan enable and a 3-bit status code for a debug display. While the robot moves, each straight or pivot segment is recorded as a direction and a tick count on a 16-entry stack. The return trip pops these segments and plays them back inverted. Two tick budgets guard the run. If either one is exceeded, all actuators are shut off and the block waits for reset.

Top module: `flame_seeker`

## Requirements
- R1: After reset, and until a start press is seen, status reads 0 (idle) and every motor enable and the fan enable are low.
- R2: A press of `start_btn` moves status to 1 (seeking). From then on the run completes with no further operator input.
- R3: While seeking with no sensor lit, the robot alternates between a clockwise pivot (left wheel forward, right wheel reverse; pattern lf,lr,rf,rr = 1001) and a forward run (1010). It never shows the left pivot (0110) or reverse (0101).
- R4: While seeking, a lit left sensor gives a left pivot (0110), a lit right sensor gives a right pivot (1001), and a lit middle sensor gives forward motion (1010).
- R5: When several sensors are lit at once, middle wins over left, and left wins over right.
- R6: Each sensor passes through a two-flop synchronizer. A new level is taken only after it has been seen on `STABLE_TICKS` consecutive ticks, so a shorter pulse has no effect on the motors.
- R7: Once the middle sensor has been lit through `CLOSE_TICKS` consecutive ticks of forward motion, status becomes 2 (extinguishing). The wheels stop and the fan is on, and it stays on only while the filtered middle sensor is lit.
- R8: When the filtered middle sensor goes dark during extinguishing, the fan turns off and status becomes 3 (returning).
- R9: During return, the recorded segments play back newest first, each with its direction inverted (forward and reverse swap, left and right pivots swap) and held for the same number of ticks. When the stack is empty, status becomes 4 (done) with the wheels stopped, and it holds. At most 16 segments are kept, and later ones are dropped.
- R10: If `SEEK_BUDGET` ticks elapse after start without the return phase being reached, status becomes 7 (fault). Every motor and fan enable drops, and this holds until reset whatever the sensors do.
- R11: If the return phase lasts `HOME_BUDGET` ticks, status becomes 7 with all enables low and held.
- R12: A wheel never has both enables high. Any change of a wheel's direction passes through at least one tick with that wheel idle, and motor outputs change only on a tick (or to off on a fault).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock timebase pulse |
| start_btn | input | 1 | Start push-button, asynchronous |
| sens_l | input | 1 | Left light comparator, asynchronous |
| sens_m | input | 1 | Middle light comparator, asynchronous |
| sens_r | input | 1 | Right light comparator, asynchronous |
| motl_fwd | output | 1 | Left wheel forward enable |
| motl_rev | output | 1 | Left wheel reverse enable |
| motr_fwd | output | 1 | Right wheel forward enable |
| motr_rev | output | 1 | Right wheel reverse enable |
| fan_on | output | 1 | Blower enable |
| status | output | 3 | 0 idle, 1 seek, 2 extinguish, 3 return, 4 done, 7 fault |

## Verification
The situation hardest to reach from the ports is a fault during the return trip. It needs a recorded path long enough that its replay, idle ticks included, runs past the return budget, while the stack still stays under its depth. The bench gets there by letting the robot search with all sensors dark for dozens of ticks, which builds up many pivot and forward segments. It then lights the middle sensor until extinguishing begins and darkens it again, and it counts ticks from the first return sample to the fault. A second run confirms that the replay is exact: it tallies the ticks spent in each motion pattern during seeking and compares them with the inverted tallies during return.

// File: rtl/flame_seeker.sv
module flame_seeker #(
  parameter int STABLE_TICKS = 4,
  parameter int SWEEP_TICKS  = 40,
  parameter int RUN_TICKS    = 30,
  parameter int CLOSE_TICKS  = 50,
  parameter int SEEK_BUDGET  = 30000,
  parameter int HOME_BUDGET  = 12000,
  parameter int STACK_DEPTH  = 16,
  parameter int SEG_W        = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start_btn,
  input  logic       sens_l,
  input  logic       sens_m,
  input  logic       sens_r,
  output logic       motl_fwd,
  output logic       motl_rev,
  output logic       motr_fwd,
  output logic       motr_rev,
  output logic       fan_on,
  output logic [2:0] status
);
  localparam int DB_W   = $clog2(STABLE_TICKS + 1);
  localparam int PH_MAX = (SWEEP_TICKS > RUN_TICKS) ? SWEEP_TICKS : RUN_TICKS;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int CL_W   = $clog2(CLOSE_TICKS + 1);
  localparam int B_MAX  = (SEEK_BUDGET > HOME_BUDGET) ? SEEK_BUDGET : HOME_BUDGET;
  localparam int BUD_W  = $clog2(B_MAX + 1);
  localparam int IDX_W  = $clog2(STACK_DEPTH);
  localparam int SP_W   = $clog2(STACK_DEPTH + 1);

  localparam logic [2:0] D_STOP = 3'd0, D_FWD = 3'd1, D_REV = 3'd2,
                         D_LEFT = 3'd3, D_RIGHT = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_SEEK = 3'd1, S_BLOW = 3'd2,
    S_HOME = 3'd3, S_DONE = 3'd4, S_FAULT = 3'd7
  } state_t;

  function automatic logic [2:0] flip(input logic [2:0] d);
    case (d)
      D_FWD:   flip = D_REV;
      D_REV:   flip = D_FWD;
      D_LEFT:  flip = D_RIGHT;
      D_RIGHT: flip = D_LEFT;
      default: flip = D_STOP;
    endcase
  endfunction

  state_t            state;
  logic [2:0]        raw, sync1, sync2, filt;
  logic [DB_W-1:0]   dbc [3];
  logic [1:0]        st_s;
  logic [2:0]        dir, cmd, nxt_dir, h_dir;
  logic [SEG_W-1:0]  seg_cnt, h_left;
  logic [SP_W-1:0]   sp;
  logic [PH_W-1:0]   sw_cnt, sw_lim;
  logic              sw_fwd;
  logic [CL_W-1:0]   close_cnt;
  logic [BUD_W-1:0]  budget;
  logic [2:0]        stk_dir [STACK_DEPTH];
  logic [SEG_W-1:0]  stk_cnt [STACK_DEPTH];
  logic [IDX_W-1:0]  top_idx;
  logic              push, pop, live;

  assign raw     = {sens_l, sens_m, sens_r};
  assign sw_lim  = sw_fwd ? PH_W'(RUN_TICKS - 1) : PH_W'(SWEEP_TICKS - 1);
  assign top_idx = IDX_W'(sp - 1'b1);
  assign nxt_dir = (dir == cmd) ? dir : ((dir == D_STOP) ? cmd : D_STOP);
  assign push    = tick && (state == S_SEEK || state == S_BLOW) && dir != D_STOP &&
                   nxt_dir != dir && sp < SP_W'(STACK_DEPTH);
  assign pop     = state == S_HOME && h_left == '0 && sp != '0;

  always_comb begin
    cmd = D_STOP;
    if (state == S_SEEK) begin
      if      (filt[1]) cmd = D_FWD;
      else if (filt[2]) cmd = D_LEFT;
      else if (filt[0]) cmd = D_RIGHT;
      else              cmd = sw_fwd ? D_FWD : D_RIGHT;
    end else if (state == S_HOME && h_left != '0) begin
      cmd = h_dir;
    end
  end

  assign live     = state != S_FAULT;
  assign motl_fwd = live && (dir == D_FWD || dir == D_RIGHT);
  assign motl_rev = live && (dir == D_REV || dir == D_LEFT);
  assign motr_fwd = live && (dir == D_FWD || dir == D_LEFT);
  assign motr_rev = live && (dir == D_REV || dir == D_RIGHT);
  assign fan_on   = state == S_BLOW && filt[1];
  assign status   = state;

  always_ff @(posedge clk) begin
    if (push) begin
      stk_dir[IDX_W'(sp)] <= dir;
      stk_cnt[IDX_W'(sp)] <= seg_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sync1 <= '0; sync2 <= '0; filt <= '0; st_s <= '0;
      for (int i = 0; i < 3; i++) dbc[i] <= '0;
      dir <= D_STOP; h_dir <= D_STOP;
      seg_cnt <= '0; h_left <= '0; sp <= '0;
      sw_cnt <= '0; sw_fwd <= 1'b0; close_cnt <= '0; budget <= '0;
    end else begin
      sync1 <= raw;
      sync2 <= sync1;
      st_s  <= {st_s[0], start_btn};
      for (int i = 0; i < 3; i++) begin
        if (sync2[i] == filt[i]) dbc[i] <= '0;
        else if (tick) begin
          if (dbc[i] == DB_W'(STABLE_TICKS - 1)) begin
            filt[i] <= sync2[i];
            dbc[i]  <= '0;
          end else dbc[i] <= dbc[i] + 1'b1;
        end
      end

      if (state == S_FAULT) dir <= D_STOP;
      else if (tick)        dir <= nxt_dir;

      if (tick && nxt_dir != D_STOP)
        seg_cnt <= (dir == nxt_dir) ? ((&seg_cnt) ? seg_cnt : seg_cnt + 1'b1) : SEG_W'(1);

      if (push) sp <= sp + 1'b1;
      else if (pop) begin
        sp     <= sp - 1'b1;
        h_dir  <= flip(stk_dir[top_idx]);
        h_left <= stk_cnt[top_idx];
      end else if (tick && state == S_HOME && h_left != '0 && nxt_dir == h_dir)
        h_left <= h_left - 1'b1;

      if (state != S_SEEK || filt != '0) begin
        sw_cnt <= '0;
        sw_fwd <= 1'b0;
      end else if (tick) begin
        if (sw_cnt == sw_lim) begin
          sw_cnt <= '0;
          sw_fwd <= ~sw_fwd;
        end else sw_cnt <= sw_cnt + 1'b1;
      end

      if (tick)
        close_cnt <= (state == S_SEEK && filt[1] && dir == D_FWD) ? close_cnt + 1'b1 : '0;

      case (state)
        S_IDLE: if (st_s[1]) begin
          state  <= S_SEEK;
          budget <= '0;
          sp     <= '0;
        end
        S_SEEK: if (tick) begin
          budget <= budget + 1'b1;
          if (budget == BUD_W'(SEEK_BUDGET - 1)) state <= S_FAULT;
          else if (filt[1] && dir == D_FWD && close_cnt == CL_W'(CLOSE_TICKS - 1))
            state <= S_BLOW;
        end
        S_BLOW: begin
          if (tick) budget <= budget + 1'b1;
          if (tick && budget == BUD_W'(SEEK_BUDGET - 1)) state <= S_FAULT;
          else if (!filt[1]) begin
            state  <= S_HOME;
            budget <= '0;
          end
        end
        S_HOME: begin
          if (tick) budget <= budget + 1'b1;
          if (tick && budget == BUD_W'(HOME_BUDGET - 1)) state <= S_FAULT;
          else if (h_left == '0 && sp == '0) state <= S_DONE;
        end
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/flame_seeker_chk.sv
module flame_seeker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       motl_fwd,
  input logic       motl_rev,
  input logic       motr_fwd,
  input logic       motr_rev,
  input logic       fan_on,
  input logic [2:0] status
);
  logic [3:0] mot;
  assign mot = {motl_fwd, motl_rev, motr_fwd, motr_rev};

  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    status == 3'd0 |-> (mot == 4'b0 && !fan_on)); // R1
  AST_FAN_IN_BLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fan_on |-> status == 3'd2); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    status == 3'd4 |=> status == 3'd4); // R9
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    status == 3'd7 |-> (mot == 4'b0 && !fan_on)); // R10
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    status == 3'd7 |=> status == 3'd7); // R11
  AST_LEFT_GAP_FR: assert property (@(posedge clk) disable iff (!rst_n)
    motl_fwd |=> !motl_rev); // R12
  AST_LEFT_GAP_RF: assert property (@(posedge clk) disable iff (!rst_n)
    motl_rev |=> !motl_fwd); // R12
  AST_RIGHT_GAP_FR: assert property (@(posedge clk) disable iff (!rst_n)
    motr_fwd |=> !motr_rev); // R12
  AST_RIGHT_GAP_RF: assert property (@(posedge clk) disable iff (!rst_n)
    motr_rev |=> !motr_fwd); // R12
  AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && status != 3'd7) |-> $stable(mot)); // R12
endmodule

bind flame_seeker flame_seeker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick),
  .motl_fwd(motl_fwd), .motl_rev(motl_rev),
  .motr_fwd(motr_fwd), .motr_rev(motr_rev),
  .fan_on(fan_on), .status(status)
);

// File: tb/sim_flame_seeker.sv
`timescale 1ns/1ps
module sim_flame_seeker;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start_btn = 1'b0;
  logic sl = 1'b0, sm = 1'b0, sr = 1'b0;
  logic motl_fwd, motl_rev, motr_fwd, motr_rev, fan_on;
  logic [2:0] status;
  int n_chk = 0, n_fail = 0, tcnt = 0;
  int sF, sL, sR, sB, hF, hL, hR, hB, both_err, gap_err;
  logic [3:0] first_home, prev;
  bit done_flag = 0;

  localparam logic [6:0] VEC [7] = '{7'b010_1010, 7'b100_0110, 7'b110_1010,
                                     7'b001_1001, 7'b011_1010, 7'b101_0110,
                                     7'b111_1010};

  flame_seeker #(.STABLE_TICKS(2), .SWEEP_TICKS(6), .RUN_TICKS(6), .CLOSE_TICKS(10),
                 .SEEK_BUDGET(150), .HOME_BUDGET(50), .STACK_DEPTH(16), .SEG_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_btn(start_btn),
    .sens_l(sl), .sens_m(sm), .sens_r(sr),
    .motl_fwd(motl_fwd), .motl_rev(motl_rev), .motr_fwd(motr_fwd), .motr_rev(motr_rev),
    .fan_on(fan_on), .status(status));

  always #4 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tcnt = (tcnt + 1) % 4;
    tick = (tcnt == 3);
  end

  function automatic logic [3:0] mot();
    return {motl_fwd, motl_rev, motr_fwd, motr_rev};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_tally();
    sF = 0; sL = 0; sR = 0; sB = 0; hF = 0; hL = 0; hR = 0; hB = 0;
    both_err = 0; gap_err = 0; first_home = 4'b0; prev = 4'b0;
  endtask

  task automatic step();
    logic [3:0] m;
    do @(posedge clk); while (!tick);
    @(negedge clk);
    m = mot();
    if ((m[3] && m[2]) || (m[1] && m[0])) both_err++;
    if ((prev[3] && m[2]) || (prev[2] && m[3]) || (prev[1] && m[0]) || (prev[0] && m[1])) gap_err++;
    prev = m;
    if (status == 3'd1 || status == 3'd2) begin
      case (m) 4'b1010: sF++; 4'b0110: sL++; 4'b1001: sR++; 4'b0101: sB++; default: ; endcase
    end else if (status == 3'd3) begin
      if (first_home == 4'b0) first_home = m;
      case (m) 4'b1010: hF++; 4'b0110: hL++; 4'b1001: hR++; 4'b0101: hB++; default: ; endcase
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start_btn = 1'b0; sl = 1'b0; sm = 1'b0; sr = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    clear_tally();
  endtask

  task automatic press();
    start_btn = 1'b1;
    step(); step();
    start_btn = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    bit saw_r, saw_f, saw_bad;
    int n;
    // Run 1: reset, idle, search, glitch, steering table
    do_reset();
    @(negedge clk);
    chk("R1 reset status", status, 0);
    chk("R1 reset motors", mot(), 0);
    chk("R1 reset fan", fan_on, 0);
    repeat (10) step();
    chk("R1 idle without start", status, 0);
    chk("R1 idle motors", mot(), 0);
    press();
    chk("R2 seek after start", status, 1);
    saw_r = 0; saw_f = 0; saw_bad = 0;
    for (int i = 0; i < 14; i++) begin
      step();
      if (mot() == 4'b1001) saw_r = 1;
      if (mot() == 4'b1010) saw_f = 1;
      if (mot() == 4'b0110 || mot() == 4'b0101) saw_bad = 1;
    end
    chk("R3 clockwise pivot seen", saw_r, 1);
    chk("R3 forward run seen", saw_f, 1);
    chk("R3 no left or reverse", saw_bad, 0);
    sl = 1'b1;
    repeat (4) @(negedge clk);
    sl = 1'b0;
    saw_bad = 0;
    for (int i = 0; i < 6; i++) begin
      step();
      if (motl_rev) saw_bad = 1;
    end
    chk("R6 short pulse ignored", saw_bad, 0);
    for (int i = 0; i < 7; i++) begin
      {sl, sm, sr} = VEC[i][6:4];
      repeat (7) step();
      chk(($countones(VEC[i][6:4]) > 1) ? "R5 priority" : "R4 steering", mot(), VEC[i][3:0]);
    end
    chk("R2 still seeking unattended", status, 1);

    // Run 2: full mission and exact replay
    do_reset();
    press();
    sl = 1'b1; repeat (8) step();
    sl = 1'b0; sr = 1'b1; repeat (8) step();
    sr = 1'b0; sm = 1'b1;
    n = 0;
    while (status != 3'd2 && n < 30) begin step(); n++; end
    chk("R7 extinguish reached", status, 2);
    step(); step();
    chk("R7 wheels stopped", mot(), 0);
    chk("R7 fan on", fan_on, 1);
    repeat (6) step();
    chk("R7 fan held while lit", fan_on, 1);
    sm = 1'b0;
    n = 0;
    while (status != 3'd3 && n < 10) begin step(); n++; end
    chk("R8 return entered", status, 3);
    chk("R8 fan off", fan_on, 0);
    n = 0;
    while (status != 3'd4 && n < 60) begin step(); n++; end
    chk("R9 done reached", status, 4);
    chk("R9 first return move is reverse", first_home, 4'b0101);
    chk("R9 reverse ticks equal forward ticks", hB, sF);
    chk("R9 left replay equals right ticks", hL, sR);
    chk("R9 right replay equals left ticks", hR, sL);
    chk("R9 no forward in return", hF, sB);
    repeat (5) step();
    chk("R9 done holds stopped", mot(), 0);
    chk("R12 never both enables", both_err, 0);
    chk("R12 idle tick between directions", gap_err, 0);

    // Run 3: seek budget
    do_reset();
    press();
    repeat (146) step();
    chk("R10 before budget", status, 1);
    repeat (4) step();
    chk("R10 fault on seek budget", status, 7);
    chk("R10 motors off", mot(), 0);
    sm = 1'b1;
    repeat (20) step();
    chk("R10 fault held", status, 7);
    chk("R10 still off", {mot(), fan_on}, 0);

    // Run 4: return budget
    do_reset();
    press();
    repeat (56) step();
    sm = 1'b1;
    n = 0;
    while (status != 3'd2 && n < 30) begin step(); n++; end
    sm = 1'b0;
    n = 0;
    while (status != 3'd3 && n < 10) begin step(); n++; end
    chk("R11 return entered", status, 3);
    n = 0;
    while (status == 3'd3 && n < 80) begin step(); n++; end
    chk("R11 fault on return budget", status, 7);
    chk("R11 ticks to fault", n, 49);
    chk("R11 all off", {mot(), fan_on}, 0);
    chk("R12 never both enables long path", both_err, 0);
    finish_run();
  end
endmodule